// File: doc/BRIEF.md
# Clock-Phased Parallel Codec Host Bus Front End

This block sits between a byte-wide host bus and the digital core of a voice codec. A host reaches it with an active-low chip select, a select line that marks the access as PCM data or as a control access, and a slow bus clock. The level of the bus clock when chip select falls sets the direction of the access. If the bus clock is low, the host writes a byte into the block. If it is high, the block drives a byte onto the bus.

A PCM byte written by the host lands in the receive register and starts a decode frame. A PCM byte read by the host comes from the transmit input port and starts an encode frame. A control write updates a six-bit mode register, which is decoded into a clock-rate code, loopback modes, a power-down level and a law-variant flag. A control read returns that register.

The bus signals are asynchronous to the system clock. They are brought in through a multi-stage synchronizer and oversampled. All outputs come from registers. The bus is modelled as separate input, output and output-enable ports, and the pad combines them.

Top module: `pbus_codec_if`

## Requirements
- R1: At the synchronized falling edge of `cs_n`, `bclk` low starts a host write (bus into block) and `bclk` high starts a host read (block onto bus). Every output responds `SYNC_STAGES` system clocks after the input change that caused it.
- R2: In a host write, the block keeps the bus byte sampled during the last system clock of the `bclk` high phase. It commits that byte when the falling edge of `bclk` is detected.
- R3: In a host read, `bus_oe` rises at the next falling edge of `bclk` and falls at the following rising edge. `bus_out` stays constant while `bus_oe` is high, and `bus_oe` is low at all other times.
- R4: `ctl_sel` is sampled at the falling edge of `cs_n`. A 0 selects PCM data and a 1 selects the control register. At most one frame-sync pulse is active at any time.
- R5: A PCM host write loads `rx_byte` with the bus byte bit-reversed, so bus bit 0 (the sign) becomes `rx_byte[7]`. It also raises `rx_fsync` for exactly one system clock. `rx_byte` changes at no other time.
- R6: A PCM host read drives `tx_byte` bit-reversed onto the bus, so `tx_byte[7]` appears on bus bit 0, and raises `tx_fsync` for one clock together with the rise of `bus_oe`. Control accesses raise no frame sync.
- R7: Control bit 0 is on bus bit 0 and control bit 1 is on bus bit 1. `clk_sel` is 0 when C0=0, 1 when C0=1 and C1=0, and 2 when C0=1 and C1=1.
- R8: Control bit 2 is on bus bit 2 and control bit 3 is on bus bit 3. C2=1 sets `dig_lpbk` and clears `ana_lpbk`. C2=0 with C3=1 sets `ana_lpbk`. Both are 0 otherwise.
- R9: Control bit 4 (bus bit 4) drives `pwr_down` and control bit 5 (bus bit 5) drives `law_rsvd`. A control read returns C0..C5 on bus bits 0..5 and 1 on bus bits 6 and 7.
- R10: While `dig_lpbk` is 1, a PCM host read drives the receive register onto the bus in place of `tx_byte`, so the bus shows the byte last written by the host.
- R11: After reset, `pwr_down` is 1, `bus_oe` is 0, the control register reads back 0xD0 and `rx_byte` is 0. While `pwr_down` is 1, PCM accesses still move data but raise no frame sync.
- R12: Once an access has started, further falling edges of `cs_n` are ignored until the access completes. An access completes even if `cs_n` rises early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Bus clock; its level at chip-select fall sets direction |
| cs_n | input | 1 | Active-low chip select |
| ctl_sel | input | 1 | 0 = PCM access, 1 = control access |
| bus_in | input | BUS_W | Data bus as seen at the pad input |
| bus_out | output | BUS_W | Data driven toward the pad |
| bus_oe | output | 1 | Pad output enable |
| tx_byte | input | BUS_W | Encoded transmit byte, MSB is the sign |
| rx_byte | output | BUS_W | Receive register, MSB is the sign |
| rx_fsync | output | 1 | One-clock receive frame-sync pulse |
| tx_fsync | output | 1 | One-clock transmit frame-sync pulse |
| clk_sel | output | 2 | Filter clock rate code |
| dig_lpbk | output | 1 | Digital loopback active |
| ana_lpbk | output | 1 | Analog loopback active |
| pwr_down | output | 1 | Power-down request |
| law_rsvd | output | 1 | Law-variant bit (1 is reserved) |

## Verification
The bench builds the block with `BUS_W` = 8 and `SYNC_STAGES` = 3 instead of the default of 2. This exercises the synchronizer depth parameter and shifts every response by one more clock than the default build would. The behavioural model in the bench takes the depth as its latency, so a wrong stage count or an extra register anywhere in the path appears as a per-clock mismatch. With bus-clock half-periods of only a few system clocks, the bench can also cover a short chip-select pulse, a chip select that falls again in mid-transfer, and back-to-back accesses in either direction.

// File: rtl/pbc_pkg.sv
`timescale 1ns/1ps
package pbc_pkg;

  // width of the mode register; bits above it read back as ones
  localparam int CTRL_W = 6;

  // bit positions inside the mode register (decoded by the control block)
  localparam int CB_CK0 = 0;
  localparam int CB_CK1 = 1;
  localparam int CB_DLB = 2;
  localparam int CB_ALB = 3;
  localparam int CB_PWD = 4;
  localparam int CB_LAW = 5;

  // reset: powered down, every other mode bit clear
  localparam logic [CTRL_W-1:0] CTRL_RST = 6'b01_0000;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_RD_ARM,
    SQ_RD_HOLD,
    SQ_WR_ARM,
    SQ_WR_DRV
  } seq_st_e;

  // rate code: 0 -> 1.024 MHz, 1 -> 0.768/0.772 MHz, 2 -> 1.28 MHz
  function automatic logic [1:0] rate_code(input logic c0, input logic c1);
    logic [1:0] r;
    if (!c0)      r = 2'd0;
    else if (!c1) r = 2'd1;
    else          r = 2'd2;
    return r;
  endfunction

endpackage

// File: rtl/pbc_sync.sv
`timescale 1ns/1ps
module pbc_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pbc_ctrl.sv
`timescale 1ns/1ps
module pbc_ctrl import pbc_pkg::*; #(
  parameter int BUS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CTRL_W-1:0] wdata,
  output logic [BUS_W-1:0]  rdback,
  output logic [1:0]        clk_sel,
  output logic              dig_lpbk,
  output logic              ana_lpbk,
  output logic              pwr_down,
  output logic              law_rsvd
);

  logic [CTRL_W-1:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mode_q <= CTRL_RST;
    else if (load) mode_q <= wdata;
  end

  // readback: implemented bits in place, the rest forced high
  for (genvar g = 0; g < BUS_W; g++) begin : g_rb
    if (g < CTRL_W) begin : g_live
      assign rdback[g] = mode_q[g];
    end else begin : g_one
      assign rdback[g] = 1'b1;
    end
  end

  assign clk_sel  = rate_code(mode_q[CB_CK0], mode_q[CB_CK1]);
  assign dig_lpbk = mode_q[CB_DLB];
  assign ana_lpbk = ~mode_q[CB_DLB] & mode_q[CB_ALB];
  assign pwr_down = mode_q[CB_PWD];
  assign law_rsvd = mode_q[CB_LAW];

endmodule

// File: rtl/pbc_seq.sv
`timescale 1ns/1ps
module pbc_seq import pbc_pkg::*; #(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_bclk,
  input  logic             s_cs_n,
  input  logic             s_sel,
  input  logic [BUS_W-1:0] s_data,
  input  logic [BUS_W-1:0] tx_byte,
  input  logic [BUS_W-1:0] rdback,
  input  logic             pd,
  input  logic             dig,
  output logic [BUS_W-1:0] rx_q,
  output logic [BUS_W-1:0] latched,
  output logic             ctl_load,
  output logic             rd_commit,
  output logic             wr_launch,
  output logic [BUS_W-1:0] bus_out,
  output logic             bus_oe,
  output logic             rx_fsync,
  output logic             tx_fsync
);

  // bus bit 0 carries the sign, so PCM bytes are mirrored at the bus
  function automatic logic [BUS_W-1:0] mirror(input logic [BUS_W-1:0] v);
    logic [BUS_W-1:0] r;
    for (int i = 0; i < BUS_W; i++) r[i] = v[BUS_W-1-i];
    return r;
  endfunction

  seq_st_e          st, st_n;
  logic             prev_bclk, prev_cs_n;
  logic             sel_q;
  logic [BUS_W-1:0] hold_q;
  logic             cs_fall, bclk_rise, bclk_fall;

  assign cs_fall   = prev_cs_n & ~s_cs_n;
  assign bclk_rise = ~prev_bclk & s_bclk;
  assign bclk_fall = prev_bclk & ~s_bclk;

  always_comb begin
    st_n      = st;
    rd_commit = 1'b0;
    wr_launch = 1'b0;
    unique case (st)
      SQ_IDLE:    if (cs_fall) st_n = s_bclk ? SQ_WR_ARM : SQ_RD_ARM;
      SQ_RD_ARM:  if (bclk_rise) st_n = SQ_RD_HOLD;
      SQ_RD_HOLD: if (bclk_fall) begin
                    st_n      = SQ_IDLE;
                    rd_commit = 1'b1;
                  end
      SQ_WR_ARM:  if (bclk_fall) begin
                    st_n      = SQ_WR_DRV;
                    wr_launch = 1'b1;
                  end
      SQ_WR_DRV:  if (bclk_rise) st_n = SQ_IDLE;
      default:    st_n = SQ_IDLE;
    endcase
  end

  assign ctl_load = rd_commit & sel_q;
  assign latched  = hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SQ_IDLE;
      prev_bclk <= 1'b0;
      prev_cs_n <= 1'b1;
      sel_q     <= 1'b0;
      hold_q    <= '0;
      rx_q      <= '0;
      bus_out   <= '0;
      bus_oe    <= 1'b0;
      rx_fsync  <= 1'b0;
      tx_fsync  <= 1'b0;
    end else begin
      st        <= st_n;
      prev_bclk <= s_bclk;
      prev_cs_n <= s_cs_n;
      if (st == SQ_IDLE && cs_fall) sel_q <= s_sel;
      if (s_bclk) hold_q <= s_data;
      if (rd_commit && !sel_q) rx_q <= mirror(hold_q);
      rx_fsync <= rd_commit & ~sel_q & ~pd;
      tx_fsync <= wr_launch & ~sel_q & ~pd;
      if (wr_launch) begin
        bus_oe  <= 1'b1;
        bus_out <= sel_q ? rdback : mirror(dig ? rx_q : tx_byte);
      end else if (st == SQ_WR_DRV && bclk_rise) begin
        bus_oe  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pbus_codec_if.sv
`timescale 1ns/1ps
module pbus_codec_if import pbc_pkg::*; #(
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk,
  input  logic             cs_n,
  input  logic             ctl_sel,
  input  logic [BUS_W-1:0] bus_in,
  output logic [BUS_W-1:0] bus_out,
  output logic             bus_oe,
  input  logic [BUS_W-1:0] tx_byte,
  output logic [BUS_W-1:0] rx_byte,
  output logic             rx_fsync,
  output logic             tx_fsync,
  output logic [1:0]       clk_sel,
  output logic             dig_lpbk,
  output logic             ana_lpbk,
  output logic             pwr_down,
  output logic             law_rsvd
);

  localparam int SW = BUS_W + 3;
  localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b1, 1'b0, {BUS_W{1'b0}}};

  logic [SW-1:0]    raw_v, syn_v;
  logic             s_bclk, s_cs_n, s_sel;
  logic [BUS_W-1:0] s_data;
  logic [BUS_W-1:0] rdback, latched;
  logic             ctl_load;
  logic             rd_commit, wr_launch;

  assign raw_v = {bclk, cs_n, ctl_sel, bus_in};
  assign {s_bclk, s_cs_n, s_sel, s_data} = syn_v;

  pbc_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_v),
    .q     (syn_v)
  );

  pbc_seq #(.BUS_W(BUS_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_bclk    (s_bclk),
    .s_cs_n    (s_cs_n),
    .s_sel     (s_sel),
    .s_data    (s_data),
    .tx_byte   (tx_byte),
    .rdback    (rdback),
    .pd        (pwr_down),
    .dig       (dig_lpbk),
    .rx_q      (rx_byte),
    .latched   (latched),
    .ctl_load  (ctl_load),
    .rd_commit (rd_commit),
    .wr_launch (wr_launch),
    .bus_out   (bus_out),
    .bus_oe    (bus_oe),
    .rx_fsync  (rx_fsync),
    .tx_fsync  (tx_fsync)
  );

  pbc_ctrl #(.BUS_W(BUS_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ctl_load),
    .wdata    (latched[CTRL_W-1:0]),
    .rdback   (rdback),
    .clk_sel  (clk_sel),
    .dig_lpbk (dig_lpbk),
    .ana_lpbk (ana_lpbk),
    .pwr_down (pwr_down),
    .law_rsvd (law_rsvd)
  );

endmodule

// File: rtl/pbus_codec_if_chk.sv
`timescale 1ns/1ps
module pbus_codec_if_chk #(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_oe,
  input logic [BUS_W-1:0] bus_out,
  input logic [BUS_W-1:0] rx_byte,
  input logic             rx_fsync,
  input logic             tx_fsync,
  input logic             pwr_down,
  input logic             wr_launch
);

  // R5
  rxf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fsync |=> !rx_fsync);

  // R5
  rx_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_byte) |-> (rx_fsync || pwr_down));

  // R6
  txf_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fsync |-> $rose(bus_oe));

  // R4
  fsync_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_fsync, tx_fsync}));

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && $past(bus_oe)) |-> $stable(bus_out));

  // R3
  oe_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> $past(wr_launch));

  // R11
  rxf_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fsync |-> !pwr_down);

endmodule

bind pbus_codec_if pbus_codec_if_chk #(.BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_oe    (bus_oe),
  .bus_out   (bus_out),
  .rx_byte   (rx_byte),
  .rx_fsync  (rx_fsync),
  .tx_fsync  (tx_fsync),
  .pwr_down  (pwr_down),
  .wr_launch (wr_launch)
);

// File: tb/pbus_codec_if_tb.sv
`timescale 1ns/1ps
module pbus_codec_if_tb;

  localparam int LAT = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bclk = 1'b0, cs_n = 1'b1, ctl_sel = 1'b0;
  logic [7:0] bus_in = 8'h00, tx_byte = 8'h00;
  logic [7:0] bus_out, rx_byte;
  logic       bus_oe, rx_fsync, tx_fsync;
  logic [1:0] clk_sel;
  logic       dig_lpbk, ana_lpbk, pwr_down, law_rsvd;

  int n_cmp = 0, n_bad = 0;
  int rx_pulses = 0, tx_pulses = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pbus_codec_if #(.BUS_W(8), .SYNC_STAGES(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .cs_n(cs_n), .ctl_sel(ctl_sel),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .tx_byte(tx_byte),
    .rx_byte(rx_byte), .rx_fsync(rx_fsync), .tx_fsync(tx_fsync),
    .clk_sel(clk_sel), .dig_lpbk(dig_lpbk), .ana_lpbk(ana_lpbk),
    .pwr_down(pwr_down), .law_rsvd(law_rsvd)
  );

  function automatic logic [7:0] rev_b(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct packed {
    logic       oe;
    logic [7:0] dout;
    logic [7:0] rx;
    logic       rxf, txf;
    logic [1:0] cks;
    logic       dl, al, pd, law;
  } snap_t;

  snap_t hist[$];
  int    ph;
  bit    mcsp, mbp, msel, moe, mrxf, mtxf;
  logic [7:0] mhold, mrx, mdout, mctrl;

  function automatic snap_t take();
    snap_t s;
    s.oe = moe; s.dout = mdout; s.rx = mrx; s.rxf = mrxf; s.txf = mtxf;
    if (mctrl[0] == 1'b0)      s.cks = 2'd0;
    else if (mctrl[1] == 1'b0) s.cks = 2'd1;
    else                       s.cks = 2'd2;
    s.dl  = mctrl[2];
    s.al  = (mctrl[2] == 1'b0) && mctrl[3];
    s.pd  = mctrl[4];
    s.law = mctrl[5];
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; mcsp = 1; mbp = 0; msel = 0; moe = 0; mrxf = 0; mtxf = 0;
      mhold = 0; mrx = 0; mdout = 0; mctrl = 8'h10;
    end else begin
      bit csf, br, bf;
      csf = mcsp && !cs_n;
      br  = !mbp && bclk;
      bf  = mbp && !bclk;
      mrxf = 0; mtxf = 0;
      case (ph)
        0: if (csf) begin msel = ctl_sel; ph = bclk ? 3 : 1; end
        1: if (br) ph = 2;
        2: if (bf) begin
             ph = 0;
             if (msel) mctrl = {2'b00, mhold[5:0]};
             else begin mrx = rev_b(mhold); mrxf = !mctrl[4]; end
           end
        3: if (bf) begin
             ph = 4; moe = 1;
             mtxf = !msel && !mctrl[4];
             mdout = msel ? {2'b11, mctrl[5:0]} : rev_b(mctrl[2] ? mrx : tx_byte);
           end
        4: if (br) begin ph = 0; moe = 0; end
        default: ph = 0;
      endcase
      if (bclk) mhold = bus_in;
      mcsp = cs_n; mbp = bclk;
    end
    hist.push_back(take());
    if (hist.size() > LAT + 1) void'(hist.pop_front());
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rx_fsync) rx_pulses++;
    if (tx_fsync) tx_pulses++;
    if (rst_n && hist.size() == LAT + 1 && !done) begin
      snap_t e;
      e = hist[0];
      check("R3 bus_oe", {7'd0, bus_oe}, {7'd0, e.oe});
      if (e.oe) check("R6 bus_out", bus_out, e.dout);
      check("R5 rx_byte", rx_byte, e.rx);
      check("R5 rx_fsync", {7'd0, rx_fsync}, {7'd0, e.rxf});
      check("R6 tx_fsync", {7'd0, tx_fsync}, {7'd0, e.txf});
      check("R7 clk_sel", {6'd0, clk_sel}, {6'd0, e.cks});
      check("R8 loopback", {6'd0, dig_lpbk, ana_lpbk}, {6'd0, e.dl, e.al});
      check("R9 pd/law", {6'd0, pwr_down, law_rsvd}, {6'd0, e.pd, e.law});
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  int oe_seen;
  always @(negedge clk) if (bus_oe) oe_seen++;

  // host puts a byte on the bus (bclk low at chip-select fall)
  task automatic host_put(input logic sel, input logic [7:0] v);
    bclk = 0; tick(4);
    ctl_sel = sel; cs_n = 0; tick(4);
    bclk = 1; bus_in = v; tick(6);
    bclk = 0; tick(2);
    cs_n = 1; bus_in = v ^ 8'h5A; tick(LAT + 6);
  endtask

  // host takes a byte from the bus (bclk high at chip-select fall)
  task automatic host_get(input logic sel, output logic [7:0] got, output logic oe_mid);
    bclk = 1; tick(4);
    ctl_sel = sel; cs_n = 0; tick(4);
    bclk = 0; tick(LAT + 3);
    got = bus_out; oe_mid = bus_oe; tick(3);
    bclk = 1; tick(2);
    cs_n = 1; tick(LAT + 6);
  endtask

  logic [7:0] got;
  logic       oem;
  int         rp0, tp0, oe0;

  initial begin
    tick(6);
    // R11 reset state
    check("R11 pwr_down", {7'd0, pwr_down}, 8'd1);
    check("R11 bus_oe", {7'd0, bus_oe}, 8'd0);
    check("R11 rx_byte", rx_byte, 8'h00);
    rst_n = 1; tick(8);

    host_get(1'b1, got, oem);
    check("R11 ctrl readback", got, 8'hD0);
    check("R3 oe in drive", {7'd0, oem}, 8'd1);
    check("R3 oe after", {7'd0, bus_oe}, 8'd0);

    // PCM write while powered down: data moves, no frame sync
    rp0 = rx_pulses; oe0 = oe_seen;
    host_put(1'b0, 8'h01);
    check("R5 rx while pd", rx_byte, 8'h80);
    check("R11 no rx_fsync pd", rx_pulses[7:0], rp0[7:0]);
    check("R1 put never drives", oe_seen[7:0], oe0[7:0]);

    host_put(1'b1, 8'h03);
    check("R7 clk_sel 2", {6'd0, clk_sel}, 8'd2);
    check("R9 powered up", {7'd0, pwr_down}, 8'd0);
    host_put(1'b1, 8'h01);
    check("R7 clk_sel 1", {6'd0, clk_sel}, 8'd1);
    host_put(1'b1, 8'h02);
    check("R7 clk_sel 0", {6'd0, clk_sel}, 8'd0);

    rp0 = rx_pulses;
    host_put(1'b0, 8'h35);
    check("R5 rx mirror", rx_byte, 8'hAC);
    check("R2 R5 one rx_fsync", rx_pulses[7:0], rp0[7:0] + 8'd1);

    tx_byte = 8'hC1; tp0 = tx_pulses;
    host_get(1'b0, got, oem);
    check("R6 tx on bus", got, 8'h83);
    check("R6 one tx_fsync", tx_pulses[7:0], tp0[7:0] + 8'd1);

    tp0 = tx_pulses; rp0 = rx_pulses;
    host_get(1'b1, got, oem);
    check("R9 R4 ctrl read", got, 8'hC2);
    check("R6 ctrl no fsync", tx_pulses[7:0] + rx_pulses[7:0], tp0[7:0] + rp0[7:0]);

    host_put(1'b1, 8'h0C);
    check("R8 dig over ana", {6'd0, dig_lpbk, ana_lpbk}, 8'd2);
    host_get(1'b0, got, oem);
    check("R10 loopback byte", got, 8'h35);
    host_put(1'b1, 8'h08);
    check("R8 ana", {6'd0, dig_lpbk, ana_lpbk}, 8'd1);
    host_put(1'b1, 8'h00);
    check("R8 normal", {6'd0, dig_lpbk, ana_lpbk}, 8'd0);
    host_put(1'b1, 8'h20);
    check("R9 law bit", {7'd0, law_rsvd}, 8'd1);
    host_get(1'b1, got, oem);
    check("R9 readback top ones", got, 8'hE0);

    // R12: short chip select, then a second fall during the transfer
    rp0 = rx_pulses;
    bclk = 0; tick(4);
    ctl_sel = 0; cs_n = 0; tick(3);
    cs_n = 1; tick(3);
    bclk = 1; bus_in = 8'h0F; tick(2);
    cs_n = 0; tick(4);
    bclk = 0; tick(6);
    cs_n = 1; tick(LAT + 8);
    check("R12 early cs completes", rx_byte, 8'hF0);
    check("R12 single pulse", rx_pulses[7:0], rp0[7:0] + 8'd1);

    // back to power-down: PCM read still drives, no tx frame sync
    host_put(1'b1, 8'hFF);
    tp0 = tx_pulses;
    host_get(1'b0, got, oem);
    check("R10 R11 pd loopback", got, 8'h0F);
    check("R11 no tx_fsync pd", tx_pulses[7:0], tp0[7:0]);

    tick(10);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL R1 watchdog expired act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule